// File: doc/BRIEF.md
# Next-Instruction Address Unit

This block owns the program counter of a 32-bit processor core whose instructions are 32 bits wide and word aligned. On every cycle it looks at the fields of the instruction at the current address, together with the two source register values, and works out the address of the next instruction. The choice is between falling through by one word, a direct jump into the current 256 MB region, a jump to an address held in a register, and a conditional branch taken when the two register operands are equal. The computed address is loaded into the PC on the rising clock edge whenever the advance input is high.

For the call form of the direct jump, the unit also raises a request to write the return address, which is the address of the following instruction, into register 31. The register file, the ALU, the instruction memory, delay slots and exceptions belong to other blocks. The next-address and link outputs are combinational from the current PC and the inputs. Only the PC is a register. All pins are plain control and data pins with no handshake: the advance input is the only form of back-pressure, and while it is low nothing moves.

Top module: `pc_steer`

## Requirements
- R1: A synchronous active-high `rst` loads `pc_q` with the reset vector (default 0x00000000) on the next rising edge.
- R2: Any opcode other than 000010, 000011 and 000100, and other than 000000 with funct 001000, gives `pc_next` = `pc_q` + 4. When `adv_en` is high, `pc_q` takes the value of `pc_next` on the rising edge.
- R3: Opcode 000010 (jump) gives `pc_next` = {(`pc_q`+4)[31:28], `jmp_tgt`[25:0], 2'b00}. The top four bits come from `pc_q`+4, not from `pc_q`.
- R4: Opcode 000011 (call) gives the same `pc_next` as R3. It also drives `link_we`=1, `link_addr`=31 and `link_data`=`pc_q`+4.
- R5: Opcode 000000 with funct 001000 (register jump) gives `pc_next` = `rs_val`, with `link_we`=0.
- R6: Opcode 000100 (branch on equal) with `rs_val`==`rt_val` gives `pc_next` = `pc_q`+4 + (sign-extended `imm16` × 4). The offset counts words and may be negative, so the reach is ±2^15 words.
- R7: Opcode 000100 with `rs_val`!=`rt_val` gives `pc_next` = `pc_q`+4.
- R8: While `adv_en` is low, `pc_q` holds its value and `link_we` is 0, even for the call opcode.
- R9: Opcode 000000 with any funct other than 001000 follows the sequential path of R2.
- R10: `link_we` is 0 for every encoding other than the call opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC is loaded on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance enable; low stalls the PC |
| op_code | input | 6 | Primary opcode, instruction bits [31:26] |
| fn_code | input | 6 | Function code, instruction bits [5:0] |
| jmp_tgt | input | 26 | Direct jump target field, instruction bits [25:0] |
| imm16 | input | 16 | Branch offset in words, instruction bits [15:0] |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Address selected for the next instruction |
| link_we | output | 1 | Return-address write request |
| link_addr | output | 5 | Destination register for the return address (31) |
| link_data | output | 32 | Return address, `pc_q`+4 |

## Verification
All 64 opcodes are swept with the other fields held fixed. This separates the three decoded opcodes from the fall-through path and shows that the link request is raised for the call opcode alone. All 64 function codes are then swept under opcode 000000, so the register jump is told apart from its R-type neighbours. The branch is tried with equal and unequal operands and with offsets of 0, +1, -1, the largest positive value and the most negative value, which exposes a missing sign extension or a byte-scaled offset. Direct jumps are issued from a PC whose next address crosses a 256 MB boundary, which tells PC+4 region bits from PC region bits. Stalled cycles with the call opcode show the hold and the suppressed link write.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam logic [5:0] OPC_SPECIAL = 6'b000000;
  localparam logic [5:0] OPC_JUMP    = 6'b000010;
  localparam logic [5:0] OPC_CALL    = 6'b000011;
  localparam logic [5:0] OPC_BEQ     = 6'b000100;
  localparam logic [5:0] FN_REGJUMP  = 6'b001000;

  typedef enum logic [2:0] {
    FLOW_SEQ    = 3'd0,
    FLOW_JUMP   = 3'd1,
    FLOW_CALL   = 3'd2,
    FLOW_REG    = 3'd3,
    FLOW_BRANCH = 3'd4
  } flow_e;

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pcs_pkg::*;
(
  input  logic [5:0] op_code,
  input  logic [5:0] fn_code,
  output flow_e      kind
);
  always_comb begin
    unique case (op_code)
      OPC_JUMP:    kind = FLOW_JUMP;
      OPC_CALL:    kind = FLOW_CALL;
      OPC_BEQ:     kind = FLOW_BRANCH;
      OPC_SPECIAL: kind = (fn_code == FN_REGJUMP) ? FLOW_REG : FLOW_SEQ;
      default:     kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/pcs_targets.sv
module pcs_targets #(
  parameter int XLEN  = 32,
  parameter int TGT_W = 26,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc_q,
  input  logic [TGT_W-1:0] jmp_tgt,
  input  logic [IMM_W-1:0] imm16,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  seq_addr,
  output logic [XLEN-1:0]  jump_addr,
  output logic [XLEN-1:0]  branch_addr,
  output logic [XLEN-1:0]  reg_addr,
  output logic             ops_equal
);
  localparam int REGION_W = XLEN - TGT_W - 2;
  localparam int EXT_W    = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(4);

  logic [XLEN-1:0] byte_offset;

  always_comb begin
    seq_addr    = pc_q + WORD_BYTES;
    jump_addr   = {seq_addr[XLEN-1 -: REGION_W], jmp_tgt, 2'b00};
    byte_offset = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};
    branch_addr = seq_addr + byte_offset;
    reg_addr    = rs_val;
    ops_equal   = (rs_val == rt_val);
  end
endmodule

// File: rtl/pcs_select.sv
module pcs_select
  import pcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_e           kind,
  input  logic            adv_en,
  input  logic            ops_equal,
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] jump_addr,
  input  logic [XLEN-1:0] branch_addr,
  input  logic [XLEN-1:0] reg_addr,
  output logic [XLEN-1:0] pc_next,
  output logic            link_we
);
  always_comb begin
    pc_next = seq_addr;
    link_we = 1'b0;
    unique case (kind)
      FLOW_JUMP:   pc_next = jump_addr;
      FLOW_CALL: begin
        pc_next = jump_addr;
        link_we = adv_en;
      end
      FLOW_REG:    pc_next = reg_addr;
      FLOW_BRANCH: pc_next = ops_equal ? branch_addr : seq_addr;
      default:     pc_next = seq_addr;
    endcase
  end
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pcs_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              TGT_W     = 26,
  parameter int              IMM_W     = 16,
  parameter int              RA_W      = 5,
  parameter logic [31:0]     RESET_VEC = 32'h0000_0000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_en,
  input  logic [5:0]       op_code,
  input  logic [5:0]       fn_code,
  input  logic [TGT_W-1:0] jmp_tgt,
  input  logic [IMM_W-1:0] imm16,
  input  logic [XLEN-1:0]  rs_val,
  input  logic [XLEN-1:0]  rt_val,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  pc_next,
  output logic             link_we,
  output logic [RA_W-1:0]  link_addr,
  output logic [XLEN-1:0]  link_data
);
  localparam logic [RA_W-1:0] LINK_REG = {RA_W{1'b1}};

  flow_e           kind;
  logic [XLEN-1:0] seq_addr, jump_addr, branch_addr, reg_addr;
  logic            ops_equal;

  pcs_decode u_decode (
    .op_code (op_code),
    .fn_code (fn_code),
    .kind    (kind)
  );

  pcs_targets #(.XLEN(XLEN), .TGT_W(TGT_W), .IMM_W(IMM_W)) u_targets (
    .pc_q        (pc_q),
    .jmp_tgt     (jmp_tgt),
    .imm16       (imm16),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .seq_addr    (seq_addr),
    .jump_addr   (jump_addr),
    .branch_addr (branch_addr),
    .reg_addr    (reg_addr),
    .ops_equal   (ops_equal)
  );

  pcs_select #(.XLEN(XLEN)) u_select (
    .kind        (kind),
    .adv_en      (adv_en),
    .ops_equal   (ops_equal),
    .seq_addr    (seq_addr),
    .jump_addr   (jump_addr),
    .branch_addr (branch_addr),
    .reg_addr    (reg_addr),
    .pc_next     (pc_next),
    .link_we     (link_we)
  );

  assign link_addr = LINK_REG;
  assign link_data = seq_addr;

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= XLEN'(RESET_VEC);
    else if (adv_en) pc_q <= pc_next;
  end

  // R1
  p_reset_vec_r1: assert property (@(posedge clk)
    rst |=> pc_q == XLEN'(RESET_VEC));

  // R2
  p_load_next_r2: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> pc_q == $past(pc_next));

  // R3
  p_jump_field_r3: assert property (@(posedge clk) disable iff (rst)
    (op_code == OPC_JUMP) |-> (pc_next[TGT_W+1:2] == jmp_tgt && pc_next[1:0] == 2'b00));

  // R4
  p_link_req_r4: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (op_code == OPC_CALL && link_addr == LINK_REG && link_data == pc_q + XLEN'(4)));

  // R5
  p_reg_jump_r5: assert property (@(posedge clk) disable iff (rst)
    (op_code == OPC_SPECIAL && fn_code == FN_REGJUMP) |-> (pc_next == rs_val && !link_we));

  // R7
  p_branch_miss_r7: assert property (@(posedge clk) disable iff (rst)
    (op_code == OPC_BEQ && rs_val != rt_val) |-> pc_next == pc_q + XLEN'(4));

  // R8
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> ($stable(pc_q) && 1'b1));

  p_stall_nolink_r8: assert property (@(posedge clk) disable iff (rst)
    !adv_en |-> !link_we);

endmodule

// File: tb/test_pc_steer.sv
`timescale 1ns/1ps
module test_pc_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_en = 1'b0;
  logic [5:0]  op_code = '0;
  logic [5:0]  fn_code = '0;
  logic [25:0] jmp_tgt = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc_q, pc_next, link_data;
  logic        link_we;
  logic [4:0]  link_addr;

  int total = 0;
  int fails = 0;
  logic [31:0] m_pc = 32'h0;

  always #2 clk = ~clk;

  pc_steer i_pc_steer (
    .clk(clk), .rst(rst), .adv_en(adv_en), .op_code(op_code), .fn_code(fn_code),
    .jmp_tgt(jmp_tgt), .imm16(imm16), .rs_val(rs_val), .rt_val(rt_val),
    .pc_q(pc_q), .pc_next(pc_next), .link_we(link_we), .link_addr(link_addr),
    .link_data(link_data)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one instruction, check combinational outputs, then the PC after the edge.
  task automatic step(input logic [5:0] op, input logic [5:0] fn, input logic [25:0] tg,
                      input logic [15:0] im, input logic [31:0] a, input logic [31:0] b,
                      input logic en, input string req);
    logic [31:0] pc4, exp_next;
    int off;
    bit exp_link;
    op_code = op; fn_code = fn; jmp_tgt = tg; imm16 = im; rs_val = a; rt_val = b; adv_en = en;
    pc4 = m_pc + 32'd4;
    off = (int'(im) >= 32768) ? int'(im) - 65536 : int'(im);
    exp_link = 1'b0;
    if (op == 6'd2 || op == 6'd3) begin
      exp_next = (pc4 & 32'hF000_0000) + 32'(int'(tg) * 4);
      exp_link = (op == 6'd3) && en;
    end else if (op == 6'd0 && fn == 6'd8) exp_next = a;
    else if (op == 6'd4 && a == b) exp_next = pc4 + 32'(off * 4);
    else exp_next = pc4;
    #1;
    chk(pc_next === exp_next, {req, " pc_next"}, pc_next, exp_next);
    chk(link_we === exp_link, {req, " link_we"}, 32'(link_we), 32'(exp_link));
    if (exp_link) begin
      chk(link_addr === 5'd31, {req, " link_addr"}, 32'(link_addr), 32'd31);
      chk(link_data === pc4, {req, " link_data"}, link_data, pc4);
    end
    @(negedge clk);
    if (en) m_pc = exp_next;
    chk(pc_q === m_pc, {req, " pc_q"}, pc_q, m_pc);
  endtask

  task automatic set_pc(input logic [31:0] v);
    step(6'd0, 6'd8, 26'd0, 16'd0, v, 32'd0, 1'b1, "R5 setpc");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1: reset state
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(pc_q === 32'h0, "R1 reset pc", pc_q, 32'h0);
    rst = 1'b0;
    m_pc = 32'h0;

    // R2, R3, R4, R6, R7, R10: full opcode sweep, operands equal and unequal
    for (int o = 0; o < 64; o++) begin
      set_pc(32'h0040_1000 + 32'(o * 64));
      step(6'(o), 6'h20, 26'h0ABCDE, 16'h0010, 32'h55, 32'h55, 1'b1, "R2 R10 opsweep eq");
      set_pc(32'h1234_5678 & 32'hFFFF_FFFC);
      step(6'(o), 6'h21, 26'h3FFFFFF, 16'hFFF0, 32'h55, 32'h56, 1'b1, "R2 R10 opsweep ne");
    end

    // R5, R9: funct sweep under the special opcode
    for (int f = 0; f < 64; f++) begin
      set_pc(32'h0000_2000);
      step(6'd0, 6'(f), 26'd0, 16'd0, 32'hDEAD_BEE0 + 32'(f * 4), 32'd0, 1'b1, "R5 R9 fnsweep");
    end

    // R6, R7: branch offsets at the boundaries
    begin
      logic [15:0] offs[5] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000};
      for (int k = 0; k < 5; k++) begin
        set_pc(32'h0010_0000);
        step(6'd4, 6'd0, 26'd0, offs[k], 32'hA5A5_0000, 32'hA5A5_0000, 1'b1, "R6 branch taken");
        set_pc(32'h0010_0000);
        step(6'd4, 6'd0, 26'd0, offs[k], 32'hA5A5_0000, 32'hA5A5_0001, 1'b1, "R7 branch not taken");
      end
    end

    // R3, R4: region bits come from PC+4 across a 256 MB boundary
    set_pc(32'hEFFF_FFFC);
    step(6'd2, 6'd0, 26'h0000123, 16'd0, 32'd0, 32'd0, 1'b1, "R3 jump region");
    set_pc(32'h7FFF_FFFC);
    step(6'd3, 6'd0, 26'h2000001, 16'd0, 32'd0, 32'd0, 1'b1, "R4 call region");

    // R8: stall holds PC and suppresses the link request
    set_pc(32'h0000_4000);
    step(6'd3, 6'd0, 26'h0000055, 16'd0, 32'd0, 32'd0, 1'b0, "R8 stall call");
    step(6'd4, 6'd0, 26'd0, 16'h0100, 32'd7, 32'd7, 1'b0, "R8 stall branch");
    step(6'd9, 6'd0, 26'd0, 16'd0, 32'd0, 32'd0, 1'b1, "R2 resume");

    // R1: reset in mid-run
    rst = 1'b1; adv_en = 1'b1;
    @(negedge clk);
    chk(pc_q === 32'h0, "R1 mid-run reset", pc_q, 32'h0);
    rst = 1'b0; m_pc = 32'h0;
    step(6'd1, 6'd0, 26'd0, 16'd0, 32'd0, 32'd0, 1'b1, "R2 after reset");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule